// File: doc/BRIEF.md
# Two-Bank SDRAM Activation Guard

This block sits between a command requester and the command pins of a two-bank SDRAM. It keeps a small state machine per bank that records whether the bank is open, which row it holds, and how many cycles have passed since that bank was last opened and last closed. A request (open row, read, write or close) is offered with a bank, a row and a column. The guard accepts it only once every spacing rule between commands holds. Until then it stalls the request and the pins carry a no-operation. A request that breaks the protocol outright is consumed and flagged as an error, and nothing reaches the pins.

Each bank runs three states. In `BK_IDLE` the bank is closed and may be opened. `BK_IDLE -> BK_ACTIVE` happens on an accepted activate. In `BK_ACTIVE` a row is open, and reads and writes to that row are allowed. `BK_ACTIVE -> BK_PRECH` happens on an accepted precharge. In `BK_PRECH` the bank waits out the precharge time. `BK_PRECH -> BK_IDLE` happens when that time has run out. `BK_PRECH -> BK_ACTIVE` happens when an activate is accepted on the first legal cycle.

The request gate gives a verdict on each cycle:
- `V_IDLE`: no request is offered.
- `V_STALL`: the request is legal but too early.
- `V_REJECT`: the request is illegal and is consumed with an error.
- `V_ISSUE`: the request is accepted and sent to the pins.

All timings are cycle-count parameters. A bank that stays open for the maximum open time raises a must-precharge flag.

Top module: `sdram_act_guard`

## Requirements
- R1: Out of reset every bank is closed. `req_ready`, `req_err` and `must_pre` are low. The pins carry NOP ({ras_n,cas_n,we_n}=3'b111) and no spacing limit applies to the first command.
- R2: A read or write to a bank that is not open is consumed in its first cycle with `req_ready`=1 and `req_err`=1, and the following pin cycle is NOP.
- R3: A read or write to an open bank is accepted no earlier than TRCD clock edges after the edge that accepted its activate.
- R4: An activate to a bank that is already open is consumed with `req_err`=1 and is not issued.
- R5: Two activates to the same bank are accepted at least TRC edges apart. After a precharge, the bank is not reopened until TRP edges have passed.
- R6: Activates to different banks are accepted at least TRRD edges apart.
- R7: A precharge is accepted no earlier than TRAS edges after that bank's activate. A precharge to a bank that is not open is consumed with `req_err`=1.
- R8: `must_pre[b]` goes high once bank b has been open for TRAS_MAX edges, and it drops when the bank is precharged.
- R9: Reads and writes to open banks whose TRCD has elapsed are accepted on consecutive cycles, whether they go to the same bank or alternate between banks.
- R10: The cycle after an acceptance, the pins carry the command with {ras_n,cas_n,we_n} set as follows:
  - activate: 011, with the row on the address.
  - read: 101, with the column on the address.
  - write: 100, with the column on the address.
  - precharge: 010, with the address zero (bit 10 low selects one bank).
  
  `sd_ba` carries the bank in every case. Request codes: 00 activate, 01 read, 10 write, 11 precharge.
- R11: A read or write whose row differs from the open row of its bank is consumed with `req_err`=1 and is not issued.
- R12: While a legal request is stalled, `req_ready` stays low and the pins carry NOP on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_cmd | input | 2 | Request code: 00 activate, 01 read, 10 write, 11 precharge |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row for activate; row check for read and write |
| req_col | input | COL_W | Starting column for read and write |
| req_ready | output | 1 | Request consumed this cycle |
| req_err | output | 1 | Consumed request was illegal and was dropped |
| must_pre | output | NUM_BANKS | Per-bank flag: open too long |
| sd_cs_n | output | 1 | Chip select (high only in reset) |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Row, column, or zero on precharge |

## Verification
The assertions inside the bank state machines and the gate check on every cycle that the rules hold:
- no issued column command comes before TRCD;
- no activate comes before TRC or TRP, or reaches an open bank;
- no precharge comes before TRAS;
- consecutive activates are never closer than TRRD;
- the must-precharge flag is only raised on an open bank;
- a stalled request yields NOP.

Only the bench scenarios can show the rest. One part is that each wait ends exactly on the first legal edge rather than later. Another is that the reject cases are consumed with an error. A third is that back-to-back column commands across both banks lose no cycle. The last is the exact encoding of each command on the pins.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

    typedef enum logic [1:0] {
        REQ_ACT = 2'b00,
        REQ_RD  = 2'b01,
        REQ_WR  = 2'b10,
        REQ_PRE = 2'b11
    } req_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_PRECH
    } bank_state_e;

    typedef enum logic [1:0] {
        V_IDLE,
        V_STALL,
        V_REJECT,
        V_ISSUE
    } verdict_e;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        PIN_NOP = 3'b111,
        PIN_ACT = 3'b011,
        PIN_RD  = 3'b101,
        PIN_WR  = 3'b100,
        PIN_PRE = 3'b010
    } pin_cmd_e;

endpackage

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_act_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int TRCD     = 3,
    parameter int TRAS     = 6,
    parameter int TRP      = 3,
    parameter int TRC      = 10,
    parameter int TRAS_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_col,
    input  logic [ROW_W-1:0] row_in,
    output logic             active_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             col_ready_o,
    output logic             pre_ready_o,
    output logic             act_ready_o,
    output logic             must_pre_o
);

    localparam int M1    = (TRC > TRAS_MAX) ? TRC : TRAS_MAX;
    localparam int M2    = (TRAS > TRP) ? TRAS : TRP;
    localparam int M3    = (M1 > M2) ? M1 : M2;
    localparam int MAXV  = (M3 > TRCD) ? M3 : TRCD;
    localparam int CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0] C_MAX   = CNT_W'(MAXV);
    localparam logic [CNT_W-1:0] C_TRCD  = CNT_W'(TRCD);
    localparam logic [CNT_W-1:0] C_TRAS  = CNT_W'(TRAS);
    localparam logic [CNT_W-1:0] C_TRP   = CNT_W'(TRP);
    localparam logic [CNT_W-1:0] C_TRC   = CNT_W'(TRC);
    localparam logic [CNT_W-1:0] C_RMAX  = CNT_W'(TRAS_MAX);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] act_cnt, pre_cnt;
    logic [ROW_W-1:0] row_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:   if (do_act) state_d = BK_ACTIVE;
            BK_ACTIVE: if (do_pre) state_d = BK_PRECH;
            BK_PRECH: begin
                if (do_act)                state_d = BK_ACTIVE;
                else if (pre_cnt >= C_TRP) state_d = BK_IDLE;
            end
            default:   state_d = BK_IDLE;
        endcase
    end

    // elapsed-cycle counters, saturating, and captured row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt <= C_MAX;
            pre_cnt <= C_MAX;
            row_q   <= '0;
        end else begin
            if (do_act)               act_cnt <= CNT_W'(1);
            else if (act_cnt < C_MAX) act_cnt <= act_cnt + CNT_W'(1);
            if (do_pre)               pre_cnt <= CNT_W'(1);
            else if (pre_cnt < C_MAX) pre_cnt <= pre_cnt + CNT_W'(1);
            if (do_act)               row_q   <= row_in;
        end
    end

    // outputs
    always_comb begin
        active_o    = 1'b0;
        col_ready_o = 1'b0;
        pre_ready_o = 1'b0;
        act_ready_o = 1'b0;
        must_pre_o  = 1'b0;
        unique case (state_q)
            BK_IDLE: act_ready_o = (act_cnt >= C_TRC);
            BK_ACTIVE: begin
                active_o    = 1'b1;
                col_ready_o = (act_cnt >= C_TRCD);
                pre_ready_o = (act_cnt >= C_TRAS);
                must_pre_o  = (act_cnt >= C_RMAX);
            end
            BK_PRECH: act_ready_o = (pre_cnt >= C_TRP) && (act_cnt >= C_TRC);
            default: ;
        endcase
    end
    assign open_row_o = row_q;

    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        do_col |-> (state_q == BK_ACTIVE) && (act_cnt >= C_TRCD)); // R3
    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (state_q != BK_ACTIVE)); // R4
    AST_TRC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (act_cnt >= C_TRC)); // R5
    AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (do_act && state_q == BK_PRECH) |-> (pre_cnt >= C_TRP)); // R5
    AST_PRE_AFTER_TRAS: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> (state_q == BK_ACTIVE) && (act_cnt >= C_TRAS)); // R7
    AST_FLAG_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        must_pre_o |-> (state_q == BK_ACTIVE)); // R8
    AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> (row_q == $past(row_in))); // R11

endmodule

// File: rtl/sdram_req_gate.sv
module sdram_req_gate
    import sdram_act_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BA_W      = 1,
    parameter int ROW_W     = 11,
    parameter int TRRD      = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  req_cmd_e                        req_cmd,
    input  logic [BA_W-1:0]                 req_bank,
    input  logic [ROW_W-1:0]                req_row,
    input  logic [NUM_BANKS-1:0]            bank_active,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
    input  logic [NUM_BANKS-1:0]            col_ready,
    input  logic [NUM_BANKS-1:0]            pre_ready,
    input  logic [NUM_BANKS-1:0]            act_ready,
    output logic                            req_ready,
    output logic                            req_err,
    output logic                            stall,
    output logic                            issue,
    output logic [NUM_BANKS-1:0]            do_act,
    output logic [NUM_BANKS-1:0]            do_pre,
    output logic [NUM_BANKS-1:0]            do_col
);

    localparam int RRD_W = $clog2(TRRD + 1) + 1;
    localparam logic [RRD_W-1:0] C_TRRD = RRD_W'(TRRD);

    logic [RRD_W-1:0] rrd_cnt;
    logic             rrd_ok, legal, timing_ok, is_open, row_hit, act_issue;
    verdict_e         verdict;

    assign rrd_ok  = (rrd_cnt >= C_TRRD);
    assign is_open = bank_active[req_bank];
    assign row_hit = (bank_row[req_bank] == req_row);

    // legality and spacing of the offered request
    always_comb begin
        legal     = 1'b0;
        timing_ok = 1'b0;
        unique case (req_cmd)
            REQ_ACT: begin
                legal     = !is_open;
                timing_ok = act_ready[req_bank] && rrd_ok;
            end
            REQ_RD, REQ_WR: begin
                legal     = is_open && row_hit;
                timing_ok = col_ready[req_bank];
            end
            REQ_PRE: begin
                legal     = is_open;
                timing_ok = pre_ready[req_bank];
            end
            default: ;
        endcase
    end

    // verdict
    always_comb begin
        if (!req_valid)      verdict = V_IDLE;
        else if (!legal)     verdict = V_REJECT;
        else if (!timing_ok) verdict = V_STALL;
        else                 verdict = V_ISSUE;
    end

    always_comb begin
        req_ready = 1'b0;
        req_err   = 1'b0;
        stall     = 1'b0;
        issue     = 1'b0;
        unique case (verdict)
            V_IDLE:   ;
            V_STALL:  stall = 1'b1;
            V_REJECT: begin req_ready = 1'b1; req_err = 1'b1; end
            V_ISSUE:  begin req_ready = 1'b1; issue   = 1'b1; end
            default:  ;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        logic hit;
        assign hit       = issue && (req_bank == BA_W'(b));
        assign do_act[b] = hit && (req_cmd == REQ_ACT);
        assign do_pre[b] = hit && (req_cmd == REQ_PRE);
        assign do_col[b] = hit && ((req_cmd == REQ_RD) || (req_cmd == REQ_WR));
    end

    assign act_issue = |do_act;

    always_ff @(posedge clk) begin
        if (!rst_n)                rrd_cnt <= C_TRRD;
        else if (act_issue)        rrd_cnt <= RRD_W'(1);
        else if (rrd_cnt < C_TRRD) rrd_cnt <= rrd_cnt + RRD_W'(1);
    end

    AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_issue && (TRRD > 1)) |=> !act_issue); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({do_act, do_pre, do_col}) <= 1); // R10
    AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !req_ready); // R12

endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
    import sdram_act_pkg::*;
#(
    parameter int BA_W  = 1,
    parameter int ROW_W = 11,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             stall,
    input  req_cmd_e         cmd,
    input  logic [BA_W-1:0]  bank,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr
);

    pin_cmd_e         pin_d, pin_q;
    logic [ROW_W-1:0] addr_d;

    always_comb begin
        pin_d  = PIN_NOP;
        addr_d = '0;
        if (issue) begin
            unique case (cmd)
                REQ_ACT: begin pin_d = PIN_ACT; addr_d = row; end
                REQ_RD:  begin pin_d = PIN_RD;  addr_d = ROW_W'(col); end
                REQ_WR:  begin pin_d = PIN_WR;  addr_d = ROW_W'(col); end
                REQ_PRE: begin pin_d = PIN_PRE; addr_d = '0; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= PIN_NOP;
            sd_cs_n <= 1'b1;
            sd_ba   <= '0;
            sd_addr <= '0;
        end else begin
            pin_q   <= pin_d;
            sd_cs_n <= 1'b0;
            sd_ba   <= issue ? bank : '0;
            sd_addr <= addr_d;
        end
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = pin_q;

    AST_NOP_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111)); // R12
    AST_ACT_CARRIES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cmd == REQ_ACT) |=> (sd_addr == $past(row)) && (sd_ba == $past(bank))); // R10

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
    import sdram_act_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int TRCD      = 3,
    parameter int TRAS      = 6,
    parameter int TRP       = 3,
    parameter int TRC       = 10,
    parameter int TRRD      = 2,
    parameter int TRAS_MAX  = 40,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_cmd,
    input  logic [BA_W-1:0]      req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    output logic                 req_ready,
    output logic                 req_err,
    output logic [NUM_BANKS-1:0] must_pre,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BA_W-1:0]      sd_ba,
    output logic [ROW_W-1:0]     sd_addr
);

    req_cmd_e                        cmd;
    logic                            stall, issue;
    logic [NUM_BANKS-1:0]            do_act, do_pre, do_col;
    logic [NUM_BANKS-1:0]            bank_active, col_ready, pre_ready, act_ready;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;

    assign cmd = req_cmd_e'(req_cmd);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_tracker #(
            .ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP),
            .TRC(TRC), .TRAS_MAX(TRAS_MAX)
        ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (do_act[b]),
            .do_pre     (do_pre[b]),
            .do_col     (do_col[b]),
            .row_in     (req_row),
            .active_o   (bank_active[b]),
            .open_row_o (bank_row[b]),
            .col_ready_o(col_ready[b]),
            .pre_ready_o(pre_ready[b]),
            .act_ready_o(act_ready[b]),
            .must_pre_o (must_pre[b])
        );
    end

    sdram_req_gate #(
        .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ROW_W(ROW_W), .TRRD(TRRD)
    ) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_cmd    (cmd),
        .req_bank   (req_bank),
        .req_row    (req_row),
        .bank_active(bank_active),
        .bank_row   (bank_row),
        .col_ready  (col_ready),
        .pre_ready  (pre_ready),
        .act_ready  (act_ready),
        .req_ready  (req_ready),
        .req_err    (req_err),
        .stall      (stall),
        .issue      (issue),
        .do_act     (do_act),
        .do_pre     (do_pre),
        .do_col     (do_col)
    );

    sdram_pin_drive #(
        .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .stall   (stall),
        .cmd     (cmd),
        .bank    (req_bank),
        .row     (req_row),
        .col     (req_col),
        .sd_cs_n (sd_cs_n),
        .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n),
        .sd_we_n (sd_we_n),
        .sd_ba   (sd_ba),
        .sd_addr (sd_addr)
    );

endmodule

// File: tb/test_sdram_act_guard.sv
module test_sdram_act_guard;

    localparam int ROW_W = 11, COL_W = 8;
    localparam int TRCD = 3, TRAS = 6, TRP = 3, TRC = 10, TRRD = 2, TRAS_MAX = 40;
    localparam logic [1:0] C_ACT = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_PRE = 2'b11;
    localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101,
                           P_WR = 3'b100, P_PRE = 3'b010;

    logic             clk = 1'b0, rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_cmd = 2'b00;
    logic [0:0]       req_bank = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_ready, req_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]       must_pre;
    logic [0:0]       sd_ba;
    logic [ROW_W-1:0] sd_addr;

    int checks = 0, errors = 0, stall_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_act_guard #(
        .NUM_BANKS(2), .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD), .TRAS(TRAS),
        .TRP(TRP), .TRC(TRC), .TRRD(TRRD), .TRAS_MAX(TRAS_MAX)
    ) i_sdram_act_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .req_err(req_err), .must_pre(must_pre),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int pins();
        return int'({sd_ras_n, sd_cas_n, sd_we_n});
    endfunction

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Offer a request at a negedge, count stalled edges, return at the negedge after acceptance
    task automatic send(input logic [1:0] c, input logic b, input int row, input int col,
                        output int waits, output logic err);
        req_valid = 1'b1; req_cmd = c; req_bank = b;
        req_row = ROW_W'(row); req_col = COL_W'(col);
        waits = 0;
        #1;
        while (!req_ready && waits < 200) begin
            @(negedge clk);
            #1;
            if (pins() != int'(P_NOP)) stall_bad++;
            waits++;
        end
        err = req_err;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 ready low", int'(req_ready), 0);
        chk("R1 err low", int'(req_err), 0);
        chk("R1 pins NOP", pins(), int'(P_NOP));
        chk("R1 flags low", int'(must_pre), 0);
    endtask

    task automatic t_unopened();
        int w; logic e;
        do_reset();
        send(C_RD, 1'b0, 1, 2, w, e);
        chk("R2 read closed wait", w, 0);
        chk("R2 read closed err", int'(e), 1);
        chk("R2 read closed pins NOP", pins(), int'(P_NOP));
        send(C_WR, 1'b1, 1, 2, w, e);
        chk("R2 write closed err", int'(e), 1);
        chk("R2 write closed pins NOP", pins(), int'(P_NOP));
    endtask

    task automatic t_rcd();
        int w; logic e;
        do_reset();
        stall_bad = 0;
        send(C_ACT, 1'b0, 5, 0, w, e);
        chk("R1 first act no wait", w, 0);
        chk("R10 act pins", pins(), int'(P_ACT));
        chk("R10 act row", int'(sd_addr), 5);
        send(C_RD, 1'b0, 5, 7, w, e);
        chk("R3 read waits TRCD", w, TRCD - 1);
        chk("R3 read no err", int'(e), 0);
        chk("R10 read pins", pins(), int'(P_RD));
        chk("R10 read column", int'(sd_addr), 7);
        chk("R12 NOP during stall", stall_bad, 0);
    endtask

    task automatic t_ras_rc();
        int w; logic e;
        do_reset();
        stall_bad = 0;
        send(C_ACT, 1'b1, 9, 0, w, e);
        send(C_PRE, 1'b1, 0, 0, w, e);
        chk("R7 precharge waits TRAS", w, TRAS - 1);
        chk("R10 precharge pins", pins(), int'(P_PRE));
        chk("R10 precharge bank", int'(sd_ba), 1);
        chk("R10 precharge addr zero", int'(sd_addr), 0);
        send(C_ACT, 1'b1, 9, 0, w, e);
        chk("R5 reopen waits TRC", w, TRC - TRAS - 1);
        send(C_PRE, 1'b0, 0, 0, w, e);
        chk("R7 precharge closed err", int'(e), 1);
        chk("R12 NOP during stall", stall_bad, 0);
    endtask

    task automatic t_trp();
        int w; logic e;
        do_reset();
        send(C_ACT, 1'b0, 3, 0, w, e);
        idle(TRC);
        send(C_PRE, 1'b0, 0, 0, w, e);
        chk("R7 late precharge no wait", w, 0);
        send(C_ACT, 1'b0, 3, 0, w, e);
        chk("R5 reopen waits TRP", w, TRP - 1);
    endtask

    task automatic t_rrd();
        int w; logic e;
        do_reset();
        send(C_ACT, 1'b0, 1, 0, w, e);
        send(C_ACT, 1'b1, 2, 0, w, e);
        chk("R6 cross act waits TRRD", w, TRRD - 1);
        chk("R6 second act bank", int'(sd_ba), 1);
        send(C_RD, 1'b1, 2, 4, w, e);
        chk("R3 bank1 read waits", w, TRCD - 1);
    endtask

    task automatic t_b2b();
        int w; logic e;
        do_reset();
        send(C_ACT, 1'b0, 1, 0, w, e);
        send(C_ACT, 1'b1, 2, 0, w, e);
        idle(4);
        send(C_RD, 1'b0, 1, 11, w, e);
        chk("R9 rd b0 no wait", w, 0);
        chk("R10 rd b0 pins", pins(), int'(P_RD));
        send(C_WR, 1'b1, 2, 12, w, e);
        chk("R9 wr b1 no wait", w, 0);
        chk("R10 wr b1 pins", pins(), int'(P_WR));
        chk("R10 wr b1 bank", int'(sd_ba), 1);
        send(C_RD, 1'b1, 2, 13, w, e);
        chk("R9 rd b1 no wait", w, 0);
        send(C_WR, 1'b0, 1, 14, w, e);
        chk("R9 wr b0 no wait", w, 0);
        chk("R10 wr b0 column", int'(sd_addr), 14);
    endtask

    task automatic t_reject();
        int w; logic e;
        do_reset();
        send(C_ACT, 1'b0, 3, 0, w, e);
        idle(3);
        send(C_ACT, 1'b0, 3, 0, w, e);
        chk("R4 act open err", int'(e), 1);
        chk("R4 act open pins NOP", pins(), int'(P_NOP));
        send(C_RD, 1'b0, 4, 1, w, e);
        chk("R11 wrong row err", int'(e), 1);
        chk("R11 wrong row pins NOP", pins(), int'(P_NOP));
        send(C_RD, 1'b0, 3, 1, w, e);
        chk("R11 right row accepted", int'(e), 0);
        chk("R11 right row pins", pins(), int'(P_RD));
    endtask

    task automatic t_flag();
        int w; logic e;
        do_reset();
        send(C_ACT, 1'b0, 8, 0, w, e);
        idle(TRAS_MAX - 2);
        chk("R8 flag low before limit", int'(must_pre[0]), 0);
        idle(1);
        chk("R8 flag high at limit", int'(must_pre[0]), 1);
        chk("R8 other bank flag low", int'(must_pre[1]), 0);
        send(C_PRE, 1'b0, 0, 0, w, e);
        chk("R8 flag drops on precharge", int'(must_pre[0]), 0);
    endtask

    initial begin
        t_reset();
        t_unopened();
        t_rcd();
        t_ras_rc();
        t_trp();
        t_rrd();
        t_b2b();
        t_reject();
        t_flag();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule